// File: doc/BRIEF.md
# Serial Register-Access Slave

This block lets an external host read and write a small bank of 8-bit registers over three serial wires: an active-low select, a serial clock and one shared data line. Here the data line is split into an input, an output and an output enable, which the pad ring joins into one bidirectional pin. Every access begins with a 16-bit command word. The command holds a direction flag, a 2-bit length code and a 13-bit start address. One or more data bytes follow it. After each whole byte the block moves on to the next address by itself.

The block also applies the power-up control rule. Out of reset it is in pin control mode. The first time select goes low it moves for good into serial control mode. At that moment it copies the level on the data line into the output-format bit, which selects single-ended or double-data-rate differential output for the converter. From then on, a register write can change that bit.

The three serial inputs are brought into the system clock domain through synchronizers, and their edges are found in that domain. Each level of the serial clock must therefore last at least four system clock cycles.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, ctrl_spi_mode is 0, out_fmt_sel is 0 and spi_sdio_oe is 0. The first falling edge of spi_cs_n sets ctrl_spi_mode to 1, and it stays 1 until the next reset.
- R2: On the select falling edge that sets ctrl_spi_mode, the level on spi_sdio_in is copied into out_fmt_sel. Later select falling edges leave out_fmt_sel unchanged.
- R3: spi_sdio_in is sampled on rising edges of spi_sclk while spi_cs_n is low. The first 16 bits are the command, most significant bit first. Bit 15 is the direction (1 = read, 0 = write), bits 14:13 are the length code and bits 12:0 are the start address.
- R4: Length codes 00, 01 and 10 transfer exactly 1, 2 and 3 data bytes. Any serial clocks after that count write nothing and leave spi_sdio_oe at 0.
- R5: Length code 11 keeps transferring bytes until spi_cs_n rises.
- R6: The address goes up by one after each complete data byte and wraps modulo 2^13 (0x1FFF is followed by 0x0000).
- R7: A write byte changes its register only after all 8 bits have arrived. A byte cut short by spi_cs_n rising is dropped.
- R8: In the data phase of a read, spi_sdio_out changes after falling edges of spi_sclk and is valid at the next rising edge. Each register is sent most significant bit first. spi_sdio_oe is 1 only during the data phase of a read.
- R9: Addresses 0 to NUM_REGS-1 hold 8-bit registers that reset to 0x00. Reads of any other address return 0x00, and writes to them change no register.
- R10: Bit 0 of register 0 is the output-format bit. A write to register 0 sets out_fmt_sel to the written bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Serial select, active low |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_sdio_in | input | 1 | Input side of the shared data line |
| spi_sdio_out | output | 1 | Output side of the shared data line |
| spi_sdio_oe | output | 1 | Drive enable for the shared data line |
| ctrl_spi_mode | output | 1 | 0 = pin control mode, 1 = serial control mode |
| out_fmt_sel | output | 1 | Output-format bit (0 = single-ended, 1 = DDR differential) |

## Verification
Some properties can be checked on every cycle, and the assertions cover those. Serial control mode is sticky and is only entered on a select falling edge. The output-format bit changes only on mode entry or on a register commit. The drive enable is never on during a write. Each committed byte is followed by an address one higher. Other behaviour shows up only in the bench scenarios, which compare each byte read back against a model: how the command fields are decoded, the exact byte counts and the clocks ignored after them, dropping a partial byte, silent unimplemented addresses, and address wrap.

// File: rtl/spi_reg_slave_pkg.sv
// Shared types for the serial register-access slave.
// Assumes: command word is 16 bits, direction in the top bit.
package spi_reg_slave_pkg;

    localparam int CMD_BITS  = 16;
    localparam int ADDR_BITS = 13;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_DATA = 2'd2,
        ST_DONE = 2'd3
    } xfer_state_t;

    typedef struct packed {
        logic                 rd;
        logic [1:0]           len;
        logic [ADDR_BITS-1:0] addr;
    } cmd_word_t;

endpackage

// File: rtl/spi_pin_sync.sv
// Brings a vector of asynchronous pins into the clk domain.
// Assumes: pins are slow relative to clk; RST_VAL gives each bit's idle level.
module spi_pin_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= pin_in;
    end

    // Remaining stages form the synchronizer chain.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign pin_sync = stage_q[STAGES-1];
endmodule

// File: rtl/spi_xfer_ctrl.sv
// Serial transfer engine: finds edges, decodes the command, counts bytes,
// steps the address and drives read data.
// Assumes: inputs are already synchronized; each sclk level lasts >= 4 clk.
module spi_xfer_ctrl
    import spi_reg_slave_pkg::*;
#(
    parameter int ADDR_W = ADDR_BITS,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_lvl,
    input  logic              sck_lvl,
    input  logic              sdi_lvl,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              fmt_load,
    output logic              fmt_val,
    output logic              spi_mode,
    output logic              xfer_rd,
    output logic              cs_fall,
    output logic              sdo,
    output logic              oe
);
    localparam int BIT_W = $clog2(DATA_W);
    localparam int CNT_W = $clog2(CMD_BITS);

    xfer_state_t       state_q;
    logic              cs_prev, sck_prev;
    logic              cs_rise, sck_rise, sck_fall;
    logic [CNT_W-1:0]  cnt_q;
    logic [1:0]        byte_idx_q;
    logic [1:0]        len_q;
    logic [CMD_BITS-2:0] shreg_q;
    cmd_word_t         cmd;
    logic [BIT_W-1:0]  bit_sel;

    assign cs_fall  = cs_prev & ~cs_lvl;
    assign cs_rise  = ~cs_prev & cs_lvl;
    assign sck_rise = ~sck_prev & sck_lvl;
    assign sck_fall = sck_prev & ~sck_lvl;
    assign cmd      = {shreg_q, sdi_lvl};
    assign bit_sel  = BIT_W'(DATA_W - 1) - cnt_q[BIT_W-1:0];
    assign oe       = (state_q == ST_DATA) && xfer_rd;

    // Edge-detect history for select and serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_prev  <= 1'b1;
            sck_prev <= 1'b0;
        end else begin
            cs_prev  <= cs_lvl;
            sck_prev <= sck_lvl;
        end
    end

    // Main sequencer: mode entry, command shift, data bytes, commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            byte_idx_q <= '0;
            len_q      <= '0;
            shreg_q    <= '0;
            rd_addr    <= '0;
            wr_addr    <= '0;
            wr_data    <= '0;
            wr_en      <= 1'b0;
            fmt_load   <= 1'b0;
            fmt_val    <= 1'b0;
            spi_mode   <= 1'b0;
            xfer_rd    <= 1'b0;
        end else begin
            wr_en    <= 1'b0;
            fmt_load <= 1'b0;
            if (cs_rise) begin
                state_q <= ST_IDLE;
            end else if (cs_fall) begin
                state_q <= ST_CMD;
                cnt_q   <= '0;
                if (!spi_mode) begin
                    spi_mode <= 1'b1;
                    fmt_load <= 1'b1;
                    fmt_val  <= sdi_lvl;
                end
            end else if (sck_rise && !cs_lvl) begin
                shreg_q <= {shreg_q[CMD_BITS-3:0], sdi_lvl};
                cnt_q   <= cnt_q + 1'b1;
                case (state_q)
                    ST_CMD: begin
                        if (cnt_q == CNT_W'(CMD_BITS - 1)) begin
                            xfer_rd    <= cmd.rd;
                            len_q      <= cmd.len;
                            rd_addr    <= cmd.addr;
                            byte_idx_q <= '0;
                            cnt_q      <= '0;
                            state_q    <= ST_DATA;
                        end
                    end
                    ST_DATA: begin
                        if (cnt_q == CNT_W'(DATA_W - 1)) begin
                            cnt_q   <= '0;
                            rd_addr <= rd_addr + 1'b1;
                            if (!xfer_rd) begin
                                wr_en   <= 1'b1;
                                wr_addr <= rd_addr;
                                wr_data <= {shreg_q[DATA_W-2:0], sdi_lvl};
                            end
                            if (len_q != 2'b11) begin
                                if (byte_idx_q == len_q) state_q <= ST_DONE;
                                else byte_idx_q <= byte_idx_q + 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Read data: present the next bit after each falling serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n)                  sdo <= 1'b0;
        else if (sck_fall && oe)     sdo <= rd_data[bit_sel];
    end
endmodule

// File: rtl/spi_reg_bank.sv
// Register bank with the output-format bit held in register 0, bit 0.
// Assumes: fmt_load and wr_en are never high in the same cycle.
module spi_reg_bank #(
    parameter int NUM_REGS = 8,
    parameter int ADDR_W   = 13,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fmt_load,
    input  logic              fmt_val,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              fmt_out
);
    localparam int                IDX_W = $clog2(NUM_REGS);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_REGS);

    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

    // Register writes; mode entry loads the format bit alone.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (wr_en && (wr_addr < LIMIT)) begin
            regs_q[wr_addr[IDX_W-1:0]] <= wr_data;
        end else if (fmt_load) begin
            regs_q[0][0] <= fmt_val;
        end
    end

    assign rd_data = (rd_addr < LIMIT) ? regs_q[rd_addr[IDX_W-1:0]] : '0;
    assign fmt_out = regs_q[0][0];
endmodule

// File: rtl/spi_reg_slave.sv
// Top: three-wire serial slave giving a host access to a register bank.
// Assumes: shared data pin is split into in/out/enable at the pad.
module spi_reg_slave
    import spi_reg_slave_pkg::*;
#(
    parameter int NUM_REGS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_n,
    input  logic spi_sclk,
    input  logic spi_sdio_in,
    output logic spi_sdio_out,
    output logic spi_sdio_oe,
    output logic ctrl_spi_mode,
    output logic out_fmt_sel
);
    localparam int ADDR_W = ADDR_BITS;
    localparam int DATA_W = 8;

    logic [2:0]        pins_sync;
    logic              cs_lvl, sck_lvl, sdi_lvl;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic              wr_en, fmt_load, fmt_val, xfer_rd, cs_fall;

    spi_pin_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   ({spi_cs_n, spi_sclk, spi_sdio_in}),
        .pin_sync (pins_sync)
    );

    assign {cs_lvl, sck_lvl, sdi_lvl} = pins_sync;

    spi_xfer_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_lvl   (cs_lvl),
        .sck_lvl  (sck_lvl),
        .sdi_lvl  (sdi_lvl),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .fmt_load (fmt_load),
        .fmt_val  (fmt_val),
        .spi_mode (ctrl_spi_mode),
        .xfer_rd  (xfer_rd),
        .cs_fall  (cs_fall),
        .sdo      (spi_sdio_out),
        .oe       (spi_sdio_oe)
    );

    spi_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .fmt_load (fmt_load),
        .fmt_val  (fmt_val),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .fmt_out  (out_fmt_sel)
    );
endmodule

// File: rtl/spi_reg_slave_chk.sv
// Cycle-level properties of the serial register slave, bound into the top.
// Assumes: the top's internal nets keep the names used in the bind.
module spi_reg_slave_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_fall,
    input logic              wr_en,
    input logic              fmt_load,
    input logic              xfer_rd,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              spi_sdio_oe,
    input logic              ctrl_spi_mode,
    input logic              out_fmt_sel
);
    // R1: serial control mode is never left once entered.
    p_mode_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_spi_mode |=> ctrl_spi_mode);

    // R1: mode entry only follows a select falling edge.
    p_mode_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_spi_mode) |-> $past(cs_fall));

    // R2 / R10: the format bit moves only on mode entry or a commit.
    p_fmt_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_fmt_sel) |-> $past(fmt_load || wr_en));

    // R8: no drive while a write is being committed.
    p_no_drive_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !spi_sdio_oe && !xfer_rd);

    // R8: drive enable only for read transfers.
    p_oe_read_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sdio_oe |-> xfer_rd);

    // R6: each committed byte leaves the address one further on, wrapping.
    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (rd_addr == ADDR_W'(wr_addr + 1'b1)));
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.ADDR_W(13)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs_fall       (cs_fall),
    .wr_en         (wr_en),
    .fmt_load      (fmt_load),
    .xfer_rd       (xfer_rd),
    .wr_addr       (wr_addr),
    .rd_addr       (rd_addr),
    .spi_sdio_oe   (spi_sdio_oe),
    .ctrl_spi_mode (ctrl_spi_mode),
    .out_fmt_sel   (out_fmt_sel)
);

// File: tb/tb_spi_reg_slave.sv
// Scoreboard bench: read tasks queue expected bytes, a monitor assembles
// driven bytes at each serial rising edge and compares them.
module tb_spi_reg_slave;
    localparam int HP = 6;   // clk cycles per serial clock level
    localparam int NREG = 8;

    logic clk = 1'b0;
    logic rst_n, cs_n, sclk, sdio;
    logic sdio_out, sdio_oe, spi_mode, fmt;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] model [NREG];
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] mon_sh = '0;
    int         mon_n = 0;

    always #10 clk = ~clk;   // 50 MHz

    spi_reg_slave dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .spi_cs_n      (cs_n),
        .spi_sclk      (sclk),
        .spi_sdio_in   (sdio),
        .spi_sdio_out  (sdio_out),
        .spi_sdio_oe   (sdio_oe),
        .ctrl_spi_mode (spi_mode),
        .out_fmt_sel   (fmt)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Monitor: collect driven bits and compare each completed byte.
    always @(posedge sclk) begin
        if (sdio_oe) begin
            mon_sh = {mon_sh[6:0], sdio_out};
            mon_n++;
            if (mon_n == 8) begin
                mon_n = 0;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected read drive", mon_sh, 0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(mon_sh == e, t, mon_sh, e);
                end
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            sclk = 1'b0; sdio = b[i];
            wait_clk(HP);
            sclk = 1'b1;
            wait_clk(HP);
        end
    endtask

    task automatic cs_start(input logic lvl);
        sdio = lvl;
        wait_clk(2);
        cs_n = 1'b0;
        wait_clk(HP);
    endtask

    task automatic cs_end;
        sclk = 1'b0;
        wait_clk(HP);
        cs_n = 1'b1;
        wait_clk(3 * HP);
        check(exp_q.size() == 0 && mon_n == 0, "R4 byte count at end of transfer",
              exp_q.size() * 8 + mon_n, 0);
    endtask

    task automatic send_cmd(input logic rd, input logic [1:0] len, input logic [12:0] addr);
        logic [15:0] w;
        w = {rd, len, addr};
        shift_bits(w[15:8], 8);
        shift_bits(w[7:0], 8);
    endtask

    task automatic wr_byte(input logic [12:0] addr, input logic [7:0] b);
        shift_bits(b, 8);
        if (addr < 13'(NREG)) model[addr[2:0]] = b;
    endtask

    task automatic rd_byte(input logic [12:0] addr, input string tag);
        exp_q.push_back((addr < 13'(NREG)) ? model[addr[2:0]] : 8'h00);
        tag_q.push_back(tag);
        shift_bits(8'h00, 8);
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdio = 1'b0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        check(spi_mode == 1'b0, "R1 reset mode", spi_mode, 0);
        check(fmt == 1'b0, "R1 reset format", fmt, 0);
        check(sdio_oe == 1'b0, "R1 reset oe", sdio_oe, 0);

        // First select edge with data line high: mode entry latches format 1.
        cs_start(1'b1);
        check(spi_mode == 1'b1, "R1 mode entry", spi_mode, 1);
        check(fmt == 1'b1, "R2 format capture", fmt, 1);
        model[0] = 8'h01;
        send_cmd(1'b0, 2'b00, 13'd1);
        wr_byte(13'd1, 8'hA5);
        cs_end();

        // Second select edge with data line low: format unchanged (R2).
        cs_start(1'b0);
        send_cmd(1'b0, 2'b01, 13'd2);
        wr_byte(13'd2, 8'h3C);
        wr_byte(13'd3, 8'hC3);
        cs_end();
        check(fmt == 1'b1, "R2 format kept", fmt, 1);
        check(spi_mode == 1'b1, "R1 mode sticky", spi_mode, 1);

        // Three-byte write then three-byte read (R3, R4, R6).
        cs_start(1'b0);
        send_cmd(1'b0, 2'b10, 13'd5);
        wr_byte(13'd5, 8'h11);
        wr_byte(13'd6, 8'h22);
        wr_byte(13'd7, 8'h33);
        cs_end();
        cs_start(1'b0);
        send_cmd(1'b1, 2'b10, 13'd1);
        rd_byte(13'd1, "R3 read 3 bytes");
        rd_byte(13'd2, "R6 read 3 bytes");
        rd_byte(13'd3, "R6 read 3 bytes");
        cs_end();

        // Streaming write, then streaming read of the whole bank (R5).
        cs_start(1'b0);
        send_cmd(1'b0, 2'b11, 13'd3);
        wr_byte(13'd3, 8'h44);
        wr_byte(13'd4, 8'h55);
        cs_end();
        cs_start(1'b0);
        send_cmd(1'b1, 2'b11, 13'd0);
        for (int a = 0; a < NREG; a++) rd_byte(13'(a), "R5 stream read");
        cs_end();

        // Extra byte after a one-byte write is ignored (R4).
        cs_start(1'b0);
        send_cmd(1'b0, 2'b00, 13'd4);
        wr_byte(13'd4, 8'h99);
        shift_bits(8'hEE, 8);
        cs_end();
        cs_start(1'b0);
        send_cmd(1'b1, 2'b01, 13'd4);
        rd_byte(13'd4, "R4 write count");
        rd_byte(13'd5, "R4 extra byte ignored");
        cs_end();

        // Extra clocks after a one-byte read: driver released (R4, R8).
        cs_start(1'b0);
        send_cmd(1'b1, 2'b00, 13'd2);
        rd_byte(13'd2, "R8 single read");
        shift_bits(8'h00, 8);
        check(sdio_oe == 1'b0, "R4 oe released", sdio_oe, 0);
        cs_end();

        // Partial write byte dropped (R7).
        cs_start(1'b0);
        send_cmd(1'b0, 2'b00, 13'd6);
        shift_bits(8'h0F, 5);
        cs_end();
        cs_start(1'b0);
        send_cmd(1'b1, 2'b00, 13'd6);
        rd_byte(13'd6, "R7 partial dropped");
        cs_end();

        // Unimplemented address aliasing register 0 low bits (R9).
        cs_start(1'b0);
        send_cmd(1'b0, 2'b00, 13'h1000);
        wr_byte(13'h1000, 8'hFE);
        cs_end();
        check(fmt == 1'b1, "R9 unimplemented write", fmt, 1);
        cs_start(1'b0);
        send_cmd(1'b1, 2'b01, 13'h1000);
        rd_byte(13'h1000, "R9 unimplemented read");
        rd_byte(13'h1001, "R9 unimplemented read");
        cs_end();

        // Address wrap from the top of the space (R6).
        cs_start(1'b0);
        send_cmd(1'b1, 2'b11, 13'h1FFF);
        rd_byte(13'h1FFF, "R6 top address");
        rd_byte(13'h0000, "R6 wrap to zero");
        cs_end();

        // Format bit through register 0 (R10).
        cs_start(1'b1);
        send_cmd(1'b0, 2'b00, 13'd0);
        wr_byte(13'd0, 8'h80);
        cs_end();
        check(fmt == 1'b0, "R10 format cleared", fmt, 0);
        cs_start(1'b0);
        send_cmd(1'b0, 2'b00, 13'd0);
        wr_byte(13'd0, 8'h81);
        cs_end();
        check(fmt == 1'b1, "R10 format set", fmt, 1);
        cs_start(1'b0);
        send_cmd(1'b1, 2'b00, 13'd0);
        rd_byte(13'd0, "R10 register 0 readback");
        cs_end();

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            check(1'b0, "watchdog", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule